// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block sits behind the serial-peripheral pins of a NOR flash slave. It handles only the commands that touch the status register. These are setting and clearing the write-enable latch, reading the status byte, and writing it. The block decides whether a status write may proceed. It bases that decision on the write-enable latch, the status-write-disable bit and the level of the active-low write-protect pin. Array access, program and erase are handled elsewhere.

The SPI pins are oversampled by the system clock, and the bus is mode 0. The master presents bits MSB first and the slave samples them on a rising SCLK edge. The slave drives MISO after a falling SCLK edge. A transaction is framed by CS# low. When a status write is refused, a one-clock flag tells the surrounding logic.

A parameter chooses the length of the status write. The one-byte form carries only the disable bit. The two-byte form also carries a quad-enable bit, which the status byte then reports.

Top module: `spi_stat_guard`

## Requirements
- R1: After reset the write-enable latch, the status-write-disable bit (SWD) and the quad-enable bit are clear. The write-protect pin is taken as high, MISO is low and the refusal flag is low.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either one takes effect only if CS# rises with exactly that one byte sent.
- R3: After opcode 0x05 the slave returns the status byte for as long as CS# stays low. It sends MSB first and changes MISO only after a falling SCLK edge. The layout is bit 7 = SWD, bit 6 = quad-enable (two-byte variant only, else 0), bit 1 = write-enable latch, and all other bits 0.
- R4: A status write (opcode 0x01) issued while the write-enable latch is clear is refused. It collects no data and changes no status bit.
- R5: A status write is also refused when the write-protect pin, sampled as the opcode completes, is low while SWD is 1. With the pin high, or with SWD at 0, the write proceeds.
- R6: An accepted status write loads SWD from bit 7 of the first data byte. It clears the write-enable latch once its last data byte arrives.
- R7: With WRSR_BYTES=2 the write needs two data bytes and loads quad-enable from bit 1 of the second byte. If CS# rises before the second byte arrives, nothing changes. With WRSR_BYTES=1 the write completes on the first byte and later bytes are ignored.
- R8: Each refused status write raises `wrsr_reject` for exactly one clock, in the clock after the opcode's last bit is sampled.
- R9: Commands cut off mid-byte are discarded when CS# rises. Opcodes other than the four listed, and bytes beyond those a command uses, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| wp_n | input | 1 | Write-protect pin, active low, level sensitive |
| miso | output | 1 | Serial data to the master |
| wrsr_reject | output | 1 | One-clock pulse when a status write is refused |

## Verification
The guard is exercised with every pairing of latch state, SWD value and write-protect level. This separates refusals caused by the latch from those caused by hardware protection. Two instances, one per payload length, receive the same bursts. Writes cut short after one data byte therefore show the difference between the variants. The bursts include truncated opcodes, extra bytes after the latch commands and unknown opcodes, to show that the discard paths leave the status intact. Long status reads confirm that the byte repeats. Random bursts from a fixed seed mix all of these and are checked against a bench model of both variants.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SG_BYTE_W = 8;

  localparam logic [SG_BYTE_W-1:0] OPC_WRSR = 8'h01;
  localparam logic [SG_BYTE_W-1:0] OPC_WRDI = 8'h04;
  localparam logic [SG_BYTE_W-1:0] OPC_RDSR = 8'h05;
  localparam logic [SG_BYTE_W-1:0] OPC_WREN = 8'h06;

  localparam int SR_WEL_POS  = 1;
  localparam int SR_QE_POS   = 6;
  localparam int SR_SWD_POS  = 7;
  localparam int WR_QE_SRC   = 1;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ARM_SET,
    ST_ARM_CLR,
    ST_READ,
    ST_DATA0,
    ST_DATA1,
    ST_DRAIN
  } dec_state_e;
endpackage

// File: rtl/sg_spi_shifter.sv
module sg_spi_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              byte_done_o,
  output logic              cs_release_o,
  output logic              at_boundary_o,
  output logic              miso_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q, cs_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              miso_d;
  logic              rise, fall;

  assign rise          = ~cs_n_i & sclk_i & ~sclk_q;
  assign fall          = ~cs_n_i & ~sclk_i & sclk_q;
  assign cs_release_o  = cs_n_i & ~cs_q;
  assign at_boundary_o = (cnt_q == '0);
  assign rx_byte_o     = {rx_q[BYTE_W-2:0], mosi_i};
  assign byte_done_o   = rise && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    miso_d = miso_o;
    if (cs_n_i) begin
      cnt_d  = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (rise) begin
        rx_d  = rx_byte_o;
        cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end
      if (tx_load_i) begin
        tx_d = tx_byte_i;
      end else if (fall) begin
        miso_d = tx_q[BYTE_W-1];
        tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_o <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_n_i;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      miso_o <= miso_d;
    end
  end

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_o) |-> $past(fall || cs_n_i)); // R3
endmodule

// File: rtl/sg_status_bank.sv
module sg_status_bank #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              commit_i,
  input  logic              commit_swd_i,
  input  logic              commit_qe_i,
  output logic              wel_o,
  output logic              swd_o,
  output logic [BYTE_W-1:0] status_o
);
  import sg_pkg::*;

  logic wel_d, swd_d, qe_q, qe_d;

  always_comb begin
    wel_d = wel_o;
    swd_d = swd_o;
    qe_d  = qe_q;
    if (set_wel_i) wel_d = 1'b1;
    if (clr_wel_i) wel_d = 1'b0;
    if (commit_i) begin
      wel_d = 1'b0;
      swd_d = commit_swd_i;
      qe_d  = commit_qe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_o <= 1'b0;
      swd_o <= 1'b0;
      qe_q  <= 1'b0;
    end else begin
      wel_o <= wel_d;
      swd_o <= swd_d;
      qe_q  <= qe_d;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[SR_WEL_POS] = wel_o;
    status_o[SR_QE_POS]  = qe_q;
    status_o[SR_SWD_POS] = swd_o;
  end

  AST_COMMIT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> !wel_o); // R6
  AST_SWD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(swd_o)); // R4
endmodule

// File: rtl/sg_cmd_decoder.sv
module sg_cmd_decoder #(
  parameter int BYTE_W     = 8,
  parameter int WRSR_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              cs_release_i,
  input  logic              at_boundary_i,
  input  logic              wel_i,
  input  logic              swd_i,
  input  logic              wp_lvl_i,
  output logic              set_wel_o,
  output logic              clr_wel_o,
  output logic              commit_o,
  output logic              commit_swd_o,
  output logic              commit_qe_o,
  output logic              tx_load_o,
  output logic              reject_o
);
  import sg_pkg::*;

  localparam bit TWO_BYTE = (WRSR_BYTES == 2);

  dec_state_e st_q, st_d;
  logic       rej_d;
  logic       hold_en, hold_q;
  logic       locked;

  assign locked       = ~wel_i | (~wp_lvl_i & swd_i);
  assign commit_swd_o = TWO_BYTE ? hold_q : rx_byte_i[SR_SWD_POS];
  assign commit_qe_o  = TWO_BYTE ? rx_byte_i[WR_QE_SRC] : 1'b0;

  always_comb begin
    st_d      = st_q;
    set_wel_o = 1'b0;
    clr_wel_o = 1'b0;
    commit_o  = 1'b0;
    tx_load_o = 1'b0;
    rej_d     = 1'b0;
    hold_en   = 1'b0;
    if (cs_release_i) begin
      if (at_boundary_i) begin
        set_wel_o = (st_q == ST_ARM_SET);
        clr_wel_o = (st_q == ST_ARM_CLR);
      end
      st_d = ST_OPC;
    end else if (byte_done_i) begin
      unique case (st_q)
        ST_OPC: begin
          if (rx_byte_i == OPC_WREN) begin
            st_d = ST_ARM_SET;
          end else if (rx_byte_i == OPC_WRDI) begin
            st_d = ST_ARM_CLR;
          end else if (rx_byte_i == OPC_RDSR) begin
            st_d      = ST_READ;
            tx_load_o = 1'b1;
          end else if (rx_byte_i == OPC_WRSR) begin
            if (locked) begin
              rej_d = 1'b1;
              st_d  = ST_DRAIN;
            end else begin
              st_d = ST_DATA0;
            end
          end else begin
            st_d = ST_DRAIN;
          end
        end
        ST_READ: tx_load_o = 1'b1;
        ST_DATA0: begin
          if (TWO_BYTE) begin
            hold_en = 1'b1;
            st_d    = ST_DATA1;
          end else begin
            commit_o = 1'b1;
            st_d     = ST_DRAIN;
          end
        end
        ST_DATA1: begin
          commit_o = 1'b1;
          st_d     = ST_DRAIN;
        end
        default: st_d = ST_DRAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OPC;
      reject_o <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      reject_o <= rej_d;
      if (hold_en) hold_q <= rx_byte_i[SR_SWD_POS];
    end
  end

  AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> !reject_o); // R8
  AST_NO_DATA_WHEN_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPC && byte_done_i && !cs_release_i && rx_byte_i == OPC_WRSR && !wel_i)
    |=> (st_q != ST_DATA0 && reject_o)); // R4
  AST_PROTECTED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPC && byte_done_i && rx_byte_i == OPC_WRSR && !wp_lvl_i && swd_i)
    |=> reject_o); // R5
endmodule

// File: rtl/spi_stat_guard.sv
module spi_stat_guard #(
  parameter int WRSR_BYTES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic wrsr_reject
);
  import sg_pkg::*;

  logic                 wp_q;
  logic [SG_BYTE_W-1:0] rx_byte, status;
  logic                 byte_done, cs_release, at_boundary, tx_load;
  logic                 set_wel, clr_wel, commit, commit_swd, commit_qe;
  logic                 wel, swd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= 1'b1;
    else        wp_q <= wp_n;
  end

  sg_spi_shifter #(.BYTE_W(SG_BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .tx_load_i(tx_load), .tx_byte_i(status), .rx_byte_o(rx_byte),
    .byte_done_o(byte_done), .cs_release_o(cs_release),
    .at_boundary_o(at_boundary), .miso_o(miso)
  );

  sg_cmd_decoder #(.BYTE_W(SG_BYTE_W), .WRSR_BYTES(WRSR_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .cs_release_i(cs_release), .at_boundary_i(at_boundary), .wel_i(wel),
    .swd_i(swd), .wp_lvl_i(wp_q), .set_wel_o(set_wel), .clr_wel_o(clr_wel),
    .commit_o(commit), .commit_swd_o(commit_swd), .commit_qe_o(commit_qe),
    .tx_load_o(tx_load), .reject_o(wrsr_reject)
  );

  sg_status_bank #(.BYTE_W(SG_BYTE_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
    .commit_i(commit), .commit_swd_i(commit_swd), .commit_qe_i(commit_qe),
    .wel_o(wel), .swd_o(swd), .status_o(status)
  );

  AST_LATCH_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel && !cs_n) |=> !wel); // R2
endmodule

// File: tb/spi_stat_guard_bench.sv
module spi_stat_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso_a, miso_b, rej_a, rej_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int rej_cnt [2];
  bit m_wel [2];
  bit m_swd [2];
  bit m_qe  [2];
  int nb [2] = '{2, 1};

  spi_stat_guard #(.WRSR_BYTES(2)) u_spi_stat_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .miso(miso_a), .wrsr_reject(rej_a)
  );
  spi_stat_guard #(.WRSR_BYTES(1)) u_spi_stat_guard_one (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .miso(miso_b), .wrsr_reject(rej_b)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rej_a) rej_cnt[0]++;
    if (rej_b) rej_cnt[1]++;
  end

  function automatic logic [7:0] exp_status(int v);
    return {m_swd[v], (nb[v] == 2) ? m_qe[v] : 1'b0, 4'b0000, m_wel[v], 1'b0};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer_byte(input logic [7:0] b, input int nbits,
                           output logic [7:0] ra, output logic [7:0] rb);
    ra = '0;
    rb = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      repeat (2) @(negedge clk);
      ra[7-i] = miso_a;
      rb[7-i] = miso_b;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] op, input int n, input logic [7:0] d0,
                     input logic [7:0] d1, input logic [7:0] d2, input int trail,
                     input bit wp, input string req);
    logic [7:0] ra, rb, db;
    bit blk [2];
    logic [7:0] pre [2];
    wp_n = wp;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      blk[v] = !m_wel[v] || (!wp && m_swd[v]);
      pre[v] = exp_status(v);
      rej_cnt[v] = 0;
    end
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    xfer_byte(op, 8, ra, rb);
    for (int k = 0; k < n; k++) begin
      db = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      xfer_byte(db, 8, ra, rb);
      if (op == 8'h05) begin
        check({req, " read two-byte"}, ra, pre[0]);
        check({req, " read one-byte"}, rb, pre[1]);
      end
    end
    if (trail > 0) xfer_byte(8'($urandom), trail, ra, rb);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      if (op == 8'h06 && n == 0 && trail == 0) m_wel[v] = 1'b1;
      if (op == 8'h04 && n == 0 && trail == 0) m_wel[v] = 1'b0;
      if (op == 8'h01 && !blk[v] && n >= nb[v]) begin
        m_swd[v] = d0[7];
        if (nb[v] == 2) m_qe[v] = d1[1];
        m_wel[v] = 1'b0;
      end
      check({req, " R8 reject count"}, rej_cnt[v], (op == 8'h01 && blk[v]) ? 1 : 0);
    end
  endtask

  task automatic readback(input string req);
    txn(8'h05, 1, 8'h00, 8'h00, 8'h00, 0, wp_n, req);
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 190000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", guard);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd4242));
    for (int v = 0; v < 2; v++) begin
      m_wel[v] = 0; m_swd[v] = 0; m_qe[v] = 0; rej_cnt[v] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 miso", miso_a, 0);
    check("R1 reject", rej_a, 0);
    readback("R1");
    // R2 latch set and clear
    txn(8'h06, 0, 0, 0, 0, 0, 1, "R2");
    readback("R2");
    txn(8'h04, 0, 0, 0, 0, 0, 1, "R2");
    readback("R2");
    // R4 write without latch
    txn(8'h01, 2, 8'h80, 8'h02, 0, 0, 1, "R4");
    readback("R4");
    // R5 pin low but SWD clear: accepted; R6 and R7 loads
    txn(8'h06, 0, 0, 0, 0, 0, 0, "R2");
    txn(8'h01, 2, 8'h80, 8'h02, 0, 0, 0, "R5");
    readback("R6");
    // R5 protected: refused, latch kept
    txn(8'h06, 0, 0, 0, 0, 0, 0, "R2");
    txn(8'h01, 2, 8'h00, 8'h00, 0, 0, 0, "R5");
    readback("R5");
    // R5 pin high: accepted
    txn(8'h01, 2, 8'h00, 8'h00, 0, 0, 1, "R5");
    readback("R5");
    // R9 discards
    txn(8'h06, 0, 0, 0, 0, 3, 1, "R9");
    readback("R9");
    txn(8'h06, 1, 8'h00, 0, 0, 0, 1, "R9");
    readback("R9");
    txn(8'h9F, 1, 8'h06, 0, 0, 0, 1, "R9");
    readback("R9");
    // R7 short write differs between variants
    txn(8'h06, 0, 0, 0, 0, 0, 1, "R2");
    txn(8'h01, 1, 8'h80, 0, 0, 0, 1, "R7");
    readback("R7");
    // R3 long read
    txn(8'h05, 3, 0, 0, 0, 0, 1, "R3");
    for (int t = 0; t < 200; t++) begin
      case ($urandom % 7)
        0, 1: op = 8'h01;
        2: op = 8'h04;
        3: op = 8'h05;
        4, 5: op = 8'h06;
        default: op = 8'($urandom);
      endcase
      txn(op, $urandom % 4, 8'($urandom), 8'($urandom), 8'($urandom),
          ($urandom % 5 == 0) ? 1 + ($urandom % 7) : 0, 1'($urandom), "R2/R5/R6");
      readback("R2/R6/R9");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule